// File: doc/BRIEF.md
# Strided Transpose Read Address Generator

This block walks external memory with burst read requests and hands the returned words on to a downstream consumer. A request carries a byte address and a block-size code. The memory controller takes it with a one-cycle acknowledge. Data comes back through a read FIFO that sits outside the block. Each word leaves on a valid/ready output port.

Two stepping patterns are supported. In linear mode the address grows by one block on every accepted request. In transpose mode the address advances down a column by a fixed byte jump, once per row. When the last row of the column has been read, the address moves back to the top of the column and steps one block to the right. This pattern reads a stored image column by column, so the image comes out rotated.

A level-sensitive `start` input runs a transfer. The configuration is sampled on the cycle the transfer begins. A byte counter ends the transfer once it reaches the programmed total, or rewinds to the start address in loop mode. Taking `start` low stops a run. While the output port is stalled, no FIFO word is consumed: a word is popped only when the FIFO has data and the consumer is ready.

Top module: `strided_rd_gen`

## Requirements
- R1: After reset, `done` is 1, `req_valid` is 0, `byte_count` is 0 and `fifo_pop` is 0.
- R2: When the block is idle and `start` goes high with a nonzero `total_bytes`, `req_valid` is 1 in the following cycle. At that point `req_addr` equals `start_addr` and `req_size` equals `size_code`. The address and size stay stable until `req_ack` is seen with `start` high.
- R3: The block size in bytes is DATA_W/8 for code 0 and 8<<code for codes 1 to 5. Any code above 5 behaves as code 5.
- R4: When transpose is off, each accepted request (`req_valid` and `req_ack` both 1) makes the next address the previous one plus the block size.
- R5: When transpose is on, `jump_cfg[31:16]` is the byte jump and `jump_cfg[15:0]` is the row count minus one. A request that is not the last of its column is followed by the previous address plus the jump. The last request of a column is followed by that column's start address plus the block size.
- R6: Each accepted request adds the block size to `byte_count`. When the sum reaches or exceeds `total_bytes` and loop mode is off, `byte_count` holds that sum, `done` returns to 1 and no further request is made.
- R7: In loop mode, the accepted request that reaches the total sets `byte_count` to 0 and the next address to `start_addr`, and requests continue. `done` stays 0 for the whole run.
- R8: Starting with `total_bytes` equal to 0 makes no request, and `done` stays 1.
- R9: While a transfer runs, taking `start` low ends it. In the following cycle `req_valid` is 0 and `done` is 1.
- R10: After a finished transfer, no new request is made until `start` has gone low and then high again.
- R11: `out_valid` equals NOT `fifo_empty` and `out_data` equals `fifo_data`. `fifo_pop` is 1 exactly when `fifo_empty` is 0 and `out_ready` is 1.
- R12: Changes to `start_addr`, `total_bytes`, `size_code`, `jump_cfg`, `transpose_en` or `loop_en` during a running transfer do not alter its address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run level; rising while idle begins a transfer |
| start_addr | input | ADDR_W | First byte address |
| total_bytes | input | CNT_W | Byte count of the transfer |
| size_code | input | CODE_W | Block-size code |
| jump_cfg | input | 2*FLD_W | Upper field: jump bytes; lower field: rows minus one |
| transpose_en | input | 1 | Selects strided column stepping |
| loop_en | input | 1 | Rewind and continue on reaching the total |
| req_valid | output | 1 | Read request pending |
| req_addr | output | ADDR_W | Request byte address |
| req_size | output | CODE_W | Request block-size code |
| req_ack | input | 1 | Request accepted by memory side |
| done | output | 1 | No transfer running |
| byte_count | output | CNT_W | Live requested-byte counter |
| fifo_empty | input | 1 | Read FIFO holds no word |
| fifo_data | input | DATA_W | Read FIFO head word |
| fifo_pop | output | 1 | Consume FIFO head word |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output word |
| out_ready | input | 1 | Consumer accepts word |

## Verification
The assertions assume three things about the inputs. `req_ack` is only raised while `req_valid` is high. `total_bytes` stays far enough below the counter limit that the byte sum cannot wrap. The FIFO head word is available in the same cycle as `fifo_empty` falls. The stimulus keeps to these. The memory model acknowledges only pending requests, and after a random wait. Totals stay below a few kilobytes. The FIFO and consumer are modelled as random per-cycle levels with show-ahead data. Random transfers mix linear and transpose stepping, codes 0 to 3, small row counts and partial final blocks. Directed runs cover a zero total, a code above 5, loop rewinds, aborts and start held after completion.

// File: rtl/strd_rd_pkg.sv
package strd_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } strd_state_e;

  localparam int unsigned TOP_CODE = 5;

  // Bytes moved by one request for a given size code.
  function automatic int unsigned blk_bytes(input int unsigned code,
                                            input int unsigned word_bytes);
    int unsigned c;
    c = (code > TOP_CODE) ? TOP_CODE : code;
    if (c == 0) return word_bytes;
    return 32'd8 << c;
  endfunction

endpackage

// File: rtl/strd_addr_step.sv
module strd_addr_step #(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] base_live,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [FLD_W-1:0]  jump_q,
  input  logic [FLD_W-1:0]  rows_q,
  input  logic [ADDR_W-1:0] blk,
  input  logic              tr_q,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] col_q;
  logic [FLD_W-1:0]  row_q;
  logic              col_end;

  assign col_end = (row_q == rows_q);
  assign addr_o  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (load) begin
      addr_q <= base_live;
      col_q  <= base_live;
      row_q  <= '0;
    end else if (wrap) begin
      addr_q <= base_q;
      col_q  <= base_q;
      row_q  <= '0;
    end else if (adv) begin
      if (tr_q) begin
        if (col_end) begin
          row_q  <= '0;
          col_q  <= col_q + blk;
          addr_q <= col_q + blk;
        end else begin
          row_q  <= row_q + 1'b1;
          addr_q <= addr_q + ADDR_W'(jump_q);
        end
      end else begin
        addr_q <= addr_q + blk;
      end
    end
  end

  assert_row_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= rows_q);

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !tr_q && !load && !wrap) |=> (addr_q == $past(addr_q) + $past(blk)));

  assert_col_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tr_q && col_end && !load && !wrap) |=> (row_q == '0 && addr_q == col_q));

endmodule

// File: rtl/strd_xfer_ctl.sv
module strd_xfer_ctl
  import strd_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int CODE_W = 4,
  parameter int FLD_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [FLD_W-1:0]  jump_i,
  input  logic [FLD_W-1:0]  rows_i,
  input  logic              tr_i,
  input  logic              loop_i,
  input  logic              ack,
  output logic              req_valid,
  output logic              load,
  output logic              adv,
  output logic              wrap,
  output logic              done,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] base_q,
  output logic [FLD_W-1:0]  jump_q,
  output logic [FLD_W-1:0]  rows_q,
  output logic              tr_q,
  output logic [CODE_W-1:0] code_q,
  output logic [ADDR_W-1:0] blk
);

  localparam int unsigned WORD_B = DATA_W / 8;

  strd_state_e       state_q, state_d;
  logic [CNT_W-1:0]  total_q;
  logic              loop_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W:0]    cnt_sum;
  logic              fin;
  logic              begin_run;

  assign blk       = ADDR_W'(blk_bytes(32'(code_q), WORD_B));
  assign cnt_sum   = {1'b0, count_q} + (CNT_W+1)'(blk_bytes(32'(code_q), WORD_B));
  assign fin       = (cnt_sum >= {1'b0, total_q});
  assign begin_run = (state_q == ST_IDLE) && start;
  assign load      = begin_run && (total_i != '0);
  assign adv       = (state_q == ST_RUN) && ack;
  assign wrap      = adv && fin && loop_q;
  assign req_valid = (state_q == ST_RUN);
  assign done      = (state_q != ST_RUN);
  assign count     = count_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = (total_i != '0) ? ST_RUN : ST_HOLD;
      ST_RUN: begin
        if (!start)                   state_d = ST_IDLE;
        else if (adv && fin && !loop_q) state_d = ST_HOLD;
      end
      ST_HOLD: if (!start) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      total_q <= '0;
      loop_q  <= 1'b0;
      base_q  <= '0;
      jump_q  <= '0;
      rows_q  <= '0;
      tr_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (begin_run) begin
        total_q <= total_i;
        loop_q  <= loop_i;
        base_q  <= base_i;
        jump_q  <= jump_i;
        rows_q  <= rows_i;
        tr_q    <= tr_i;
        code_q  <= code_i;
        count_q <= '0;
      end else if (wrap) begin
        count_q <= '0;
      end else if (adv) begin
        count_q <= cnt_sum[CNT_W-1:0];
      end
    end
  end

  assert_cnt_below_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (count_q < total_q));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !start) |=> (!req_valid && done));

  assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && start) |=> !req_valid);

  assert_zero_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_run && total_i == '0) |=> (done && !req_valid));

endmodule

// File: rtl/strd_out_port.sv
module strd_out_port #(
  parameter int DATA_W = 32
) (
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              out_ready,
  output logic              fifo_pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  assign out_valid = !fifo_empty;
  assign out_data  = fifo_data;
  assign fifo_pop  = out_valid && out_ready;

endmodule

// File: rtl/strided_rd_gen.sv
module strided_rd_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CODE_W = 4,
  parameter int FLD_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [CNT_W-1:0]     total_bytes,
  input  logic [CODE_W-1:0]    size_code,
  input  logic [2*FLD_W-1:0]   jump_cfg,
  input  logic                 transpose_en,
  input  logic                 loop_en,
  output logic                 req_valid,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [CODE_W-1:0]    req_size,
  input  logic                 req_ack,
  output logic                 done,
  output logic [CNT_W-1:0]     byte_count,
  input  logic                 fifo_empty,
  input  logic [DATA_W-1:0]    fifo_data,
  output logic                 fifo_pop,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  input  logic                 out_ready
);

  logic              load, adv, wrap, tr_q;
  logic [ADDR_W-1:0] base_q, blk;
  logic [FLD_W-1:0]  jump_q, rows_q;

  strd_xfer_ctl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W), .FLD_W(FLD_W), .DATA_W(DATA_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_i(start_addr), .total_i(total_bytes), .code_i(size_code),
    .jump_i(jump_cfg[2*FLD_W-1:FLD_W]), .rows_i(jump_cfg[FLD_W-1:0]),
    .tr_i(transpose_en), .loop_i(loop_en), .ack(req_ack),
    .req_valid(req_valid), .load(load), .adv(adv), .wrap(wrap),
    .done(done), .count(byte_count),
    .base_q(base_q), .jump_q(jump_q), .rows_q(rows_q), .tr_q(tr_q),
    .code_q(req_size), .blk(blk)
  );

  strd_addr_step #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .wrap(wrap),
    .base_live(start_addr), .base_q(base_q), .jump_q(jump_q), .rows_q(rows_q),
    .blk(blk), .tr_q(tr_q), .addr_o(req_addr)
  );

  strd_out_port #(.DATA_W(DATA_W)) u_out (
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .out_ready(out_ready),
    .fifo_pop(fifo_pop), .out_valid(out_valid), .out_data(out_data)
  );

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && start) |=> (req_valid && $stable(req_addr) && $stable(req_size)));

  assert_wrap_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && start) |=> (req_addr == base_q && byte_count == '0));

  assert_pop_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (out_valid && out_ready));

endmodule

// File: tb/strided_rd_gen_bench.sv
module strided_rd_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [31:0] total_bytes = '0;
  logic [3:0]  size_code = '0;
  logic [31:0] jump_cfg = '0;
  logic        transpose_en = 1'b0;
  logic        loop_en = 1'b0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic        req_ack = 1'b0;
  logic        done;
  logic [31:0] byte_count;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_data = '0;
  logic        fifo_pop;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] exp_a [0:511];
  logic [31:0] exp_c [0:511];
  int seed_dummy;

  always #5 clk = ~clk;

  strided_rd_gen u_strided_rd_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .total_bytes(total_bytes), .size_code(size_code), .jump_cfg(jump_cfg),
    .transpose_en(transpose_en), .loop_en(loop_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_ack(req_ack), .done(done),
    .byte_count(byte_count), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int unsigned ref_blk(input logic [3:0] code);
    int unsigned c;
    c = (code > 4'd5) ? 5 : int'(code);
    return (c == 0) ? 4 : (8 << c);
  endfunction

  // Builds the expected address and counter after each accepted request; returns reads in one pass.
  function automatic int build_expect(input logic [31:0] base, input logic [31:0] total,
      input logic [3:0] code, input bit tr, input logic [15:0] jmp, input logic [15:0] rows,
      input bit lp, input int n_max);
    logic [31:0] a, col, cnt;
    logic [15:0] row;
    int unsigned b;
    int per;
    b = ref_blk(code);
    a = base; col = base; row = 0; cnt = 0; per = 0;
    for (int i = 0; i < n_max; i++) begin
      exp_a[i] = a;
      cnt = cnt + b;
      if (cnt >= total) begin
        if (per == 0) per = i + 1;
        if (!lp) begin exp_c[i] = cnt; return per; end
        cnt = 0; a = base; col = base; row = 0;
      end else if (tr) begin
        if (row == rows) begin row = 0; col = col + b; a = col; end
        else begin row = row + 1; a = a + {16'd0, jmp}; end
      end else begin
        a = a + b;
      end
      exp_c[i] = cnt;
    end
    return (per == 0) ? n_max : per;
  endfunction

  task automatic drive_stream();
    fifo_empty = ($urandom % 2) == 0;
    fifo_data  = $urandom;
    out_ready  = ($urandom % 2) == 0;
    #1;
    check(out_valid == !fifo_empty && out_data == fifo_data &&
          fifo_pop == (!fifo_empty && out_ready), "R11 stream", {fifo_pop, out_valid, 30'd0},
          {(!fifo_empty && out_ready), !fifo_empty, 30'd0});
  endtask

  // Runs one transfer; n_obs = accepted requests to observe (0 = until natural end).
  task automatic run_xfer(input logic [31:0] base, input logic [31:0] total,
      input logic [3:0] code, input bit tr, input logic [15:0] jmp, input logic [15:0] rows,
      input bit lp, input int n_req, input bit abort);
    int n_obs, per, idx;
    per = build_expect(base, total, code, tr, jmp, rows, lp, 400);
    n_obs = (n_req > 0) ? n_req : per;
    @(negedge clk);
    start_addr = base; total_bytes = total; size_code = code;
    jump_cfg = {jmp, rows}; transpose_en = tr; loop_en = lp; start = 1'b1;
    idx = 0;
    while (idx < n_obs) begin
      @(negedge clk);
      req_ack = 1'b0;
      drive_stream();
      if (req_valid) begin
        check(req_addr == exp_a[idx], tr ? "R5 addr" : (idx == 0 ? "R2 addr" : "R4 addr"),
              req_addr, exp_a[idx]);
        check(req_size == code, "R2 size", {28'd0, req_size}, {28'd0, code});
        if (lp) check(done == 1'b0, "R7 done low", {31'd0, done}, 32'd0);
        if (($urandom % 3) != 0) begin
          req_ack = 1'b1;
          idx++;
          if (idx == 1) begin
            start_addr = $urandom; total_bytes = 32'd4; size_code = 4'd1;
            jump_cfg = $urandom; transpose_en = ~tr; loop_en = ~lp;
          end
        end
      end
    end
    @(negedge clk);
    req_ack = 1'b0;
    if (abort || lp) begin
      #1;
      check(byte_count == exp_c[n_obs-1], lp ? "R7 count" : "R6 count", byte_count, exp_c[n_obs-1]);
      start = 1'b0;
      @(negedge clk); #1;
      check(req_valid == 1'b0 && done == 1'b1, "R9 abort", {req_valid, done, 30'd0}, {2'b01, 30'd0});
    end else begin
      #1;
      check(req_valid == 1'b0 && done == 1'b1, "R6 end", {req_valid, done, 30'd0}, {2'b01, 30'd0});
      check(byte_count == exp_c[n_obs-1], "R6 count", byte_count, exp_c[n_obs-1]);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        check(req_valid == 1'b0, "R10 no rearm", {31'd0, req_valid}, 32'd0);
      end
      start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    #1;
    check(done == 1'b1 && req_valid == 1'b0 && byte_count == 0 && fifo_pop == 1'b0,
          "R1 reset", {done, req_valid, fifo_pop, 29'd0}, {3'b100, 29'd0});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(done == 1'b1 && req_valid == 1'b0, "R1 after release", {done, req_valid, 30'd0}, {2'b10, 30'd0});

    // R8: zero total makes no request
    @(negedge clk);
    total_bytes = 0; start = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(req_valid == 1'b0 && done == 1'b1, "R8 zero total", {req_valid, done, 30'd0}, {2'b01, 30'd0});
    end
    start = 1'b0;
    @(negedge clk);

    // Directed: linear, partial final block (R4, R6)
    run_xfer(32'h1000_0000, 32'd70, 4'd1, 1'b0, 16'd0, 16'd0, 1'b0, 0, 1'b0);
    // Directed: transpose 12-byte rows, 3 rows (R5)
    run_xfer(32'h2000_0000, 32'd36, 4'd0, 1'b1, 16'd12, 16'd2, 1'b0, 0, 1'b0);
    // Directed: code above 5 treated as 5 (R3)
    run_xfer(32'h3000_0000, 32'd600, 4'd9, 1'b0, 16'd0, 16'd0, 1'b0, 0, 1'b0);
    // Directed: loop rewinds (R7), then abort (R9)
    run_xfer(32'h4000_0040, 32'd40, 4'd2, 1'b0, 16'd0, 16'd0, 1'b1, 7, 1'b0);
    // Directed: transpose loop
    run_xfer(32'h5000_0000, 32'd48, 4'd0, 1'b1, 16'd16, 16'd3, 1'b1, 14, 1'b0);
    // Directed: abort mid-transfer (R9)
    run_xfer(32'h6000_0000, 32'd400, 4'd1, 1'b0, 16'd0, 16'd0, 1'b0, 3, 1'b1);

    // Random transfers (R3, R4, R5, R6, R12)
    for (int t = 0; t < 30; t++) begin
      logic [3:0] code;
      logic [15:0] rows, jmp;
      logic [31:0] tot;
      bit tr;
      code = 4'($urandom % 4);
      tr = ($urandom % 2) == 1;
      rows = 16'($urandom % 4);
      jmp = 16'(($urandom % 16 + 1) * 4);
      tot = 1 + ($urandom % (ref_blk(code) * 12));
      run_xfer({$urandom % 32'h1000, 4'h0} << 8, tot, code, tr, jmp, rows, 1'b0, 0, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule